// File: doc/BRIEF.md
# Timer and Watchdog Unit

This unit pairs an 8-bit free-running timer with a watchdog counter. Each path has its own programmable prescaler. A small status pair reports whether the watchdog has timed out and whether the part has entered power-down. The timer is clocked by the system clock through its prescaler, which divides by 1:2 up to 1:256. The timer can be read and loaded at any time. It raises a single-cycle overflow pulse towards the interrupt controller when it wraps. The watchdog advances on a time-base strobe (`wdt_tick`, sampled in the system clock domain) through its own prescaler, which divides by 1:1 up to 1:128. When its 8-bit count wraps, it emits a one-cycle reset pulse.

A 7-bit control register selects both division ratios and carries an interrupt-disable bit. The bit positions are: bit 6 is the interrupt disable, bits 5:3 are the timer ratio select, and bits 2:0 are the watchdog ratio select. The register reads back as 8 bits with bit 7 always 0.

The watchdog is a three-state machine:
- `WD_OFF`: counter and prescaler held at zero.
- `WD_RUN`: counting.
- `WD_FIRE`: the single reset-pulse cycle.

Its transitions are:
- `WD_OFF` to `WD_RUN` when enabled.
- `WD_RUN` to `WD_OFF` when the enable drops.
- `WD_RUN` to `WD_FIRE` on the 256th prescaled advance with no clear in that cycle.
- `WD_FIRE` to `WD_RUN` or `WD_OFF` after one cycle, depending on the enable.

The effective enable is `wdt_en` AND `cfg_wdt_allow`.

Top module: `tmr_wdt_top`

## Requirements
- R1: After reset, `ctl_q` is 0x3F, `tmr_q` is 0, `flag_to` and `flag_pd` are 1, and `tmr_ovf` and `wdt_rst` are 0.
- R2: A `ctl_we` cycle stores `ctl_wdata` (bit 6 interrupt disable, bits 5:3 timer select, bits 2:0 watchdog select), visible on `ctl_q` one cycle later, and `ctl_q[7]` reads 0.
- R3: With timer select n, `tmr_q` advances by one every 2^(n+1) clocks. The prescaler count is compared with greater-or-equal, so a smaller ratio takes effect at once.
- R4: A `tmr_we` cycle loads `tmr_wdata` into the timer and clears its prescaler. The load wins over an increment in the same cycle and never produces an overflow pulse.
- R5: When the timer wraps from 0xFF to 0x00, `tmr_ovf` is high for exactly the one cycle in which `tmr_q` first shows 0x00.
- R6: With watchdog select n, the watchdog count advances once per 2^n `wdt_tick` strobes. Strobes are counted only in `WD_RUN`.
- R7: The watchdog runs only while both `wdt_en` and `cfg_wdt_allow` are 1. Otherwise its count and prescaler are held at zero and `wdt_rst` stays 0.
- R8: On the 256th advance, `wdt_rst` goes high for exactly one clock, starting in the next cycle, and counting restarts from zero.
- R9: At the edge that ends the `wdt_rst` cycle, the timer and its prescaler clear, `ctl_q` returns to 0x3F, and `flag_to` becomes 0, while `flag_pd` keeps its value. Writes made during that cycle are lost.
- R10: `wdt_clr` clears the watchdog count and prescaler and sets `flag_to` and `flag_pd` to 1. A clear coinciding with the 256th advance suppresses the reset pulse.
- R11: `sleep_req` clears `flag_pd`, winning over a simultaneous `wdt_clr`, and leaves `flag_to` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wdt_tick | input | 1 | Watchdog time-base strobe |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control register write data |
| ctl_q | output | 8 | Control register read value |
| tmr_we | input | 1 | Timer load strobe |
| tmr_wdata | input | 8 | Timer load value |
| tmr_q | output | 8 | Current timer value |
| tmr_ovf | output | 1 | One-cycle timer overflow pulse |
| wdt_clr | input | 1 | Watchdog clear command |
| sleep_req | input | 1 | Power-down entry strobe |
| wdt_en | input | 1 | Watchdog enable bit |
| cfg_wdt_allow | input | 1 | Hard configuration override; 0 keeps the watchdog off |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| flag_to | output | 1 | Time-out flag, 0 after a watchdog expiry |
| flag_pd | output | 1 | Power-down flag, 0 after sleep entry |

## Verification
The watchdog clear and the watchdog expiry can fall on the same edge. The bench provokes this by issuing a clear and then counting exactly 255 advances at ratio 1:1. It then drives the 256th strobe together with a second clear, and judges that `wdt_rst` stays low and `flag_to` stays high. A timer load landing on a prescaler tick, and a sleep strobe landing on a clear, are also aimed at deliberately. A long pseudo-random phase then lets all of these overlap freely against the behavioural model.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    localparam int DEF_SEL_W = 3;
    localparam int DEF_CNT_W = 8;

endpackage

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
    parameter int SEL_W = 3,
    parameter int BASE  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = (1 << SEL_W) - 1 + BASE;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        limit = CW'((32'd1 << (32'(sel) + BASE)) - 32'd1);
        tick  = adv && (cnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= tick ? '0 : cnt + CW'(1);
        end
    end

endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
    parameter int W     = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     q,
    output logic             ovf
);
    logic tick;

    tw_prescaler #(.SEL_W(SEL_W), .BASE(1)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sync_clr | wr),
        .adv   (1'b1),
        .sel   (sel),
        .tick  (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            ovf <= 1'b0;
        end else if (sync_clr) begin
            q   <= '0;
            ovf <= 1'b0;
        end else if (wr) begin
            q   <= wdata;
            ovf <= 1'b0;
        end else if (tick) begin
            q   <= q + W'(1);
            ovf <= &q;
        end else begin
            ovf <= 1'b0;
        end
    end

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sync_clr) |=> (q == $past(wdata) && !ovf)); // R4

    AST_TMR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((&q) && tick && !wr && !sync_clr) |=> (ovf && q == '0)); // R5

    AST_TMR_SYNC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (q == '0 && !ovf)); // R9

endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog
    import tw_pkg::*;
#(
    parameter int W     = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [SEL_W-1:0] sel,
    output logic             fire
);
    wd_state_e    state;
    wd_state_e    nxt;
    logic [W-1:0] cnt;
    logic         pre_clr;
    logic         pre_tick;
    logic         expire;

    assign pre_clr = (state != WD_RUN) || !enable || clr;
    assign expire  = pre_tick && (&cnt);

    tw_prescaler #(.SEL_W(SEL_W), .BASE(0)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .adv   (tick_in && !pre_clr),
        .sel   (sel),
        .tick  (pre_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (pre_clr) begin
            cnt <= '0;
        end else if (pre_tick) begin
            cnt <= cnt + W'(1);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WD_OFF:  nxt = enable ? WD_RUN : WD_OFF;
            WD_RUN: begin
                if (!enable)     nxt = WD_OFF;
                else if (expire) nxt = WD_FIRE;
                else             nxt = WD_RUN;
            end
            WD_FIRE: nxt = enable ? WD_RUN : WD_OFF;
            default: nxt = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_OFF;
        else        state <= nxt;
    end

    always_comb begin
        fire = (state == WD_FIRE);
    end

    AST_WD_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R8

    AST_WD_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !fire); // R7

    AST_WD_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && enable && state == WD_RUN) |=> !fire); // R10

endmodule

// File: rtl/tw_status_flags.sv
module tw_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_clr,
    input  logic sleep,
    input  logic wd_rst,
    output logic to,
    output logic pd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to <= 1'b1;
            pd <= 1'b1;
        end else begin
            if (wd_clr)      to <= 1'b1;
            else if (wd_rst) to <= 1'b0;
            if (sleep)       pd <= 1'b0;
            else if (wd_clr) pd <= 1'b1;
        end
    end

    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wd_clr |=> to); // R10

    AST_FLAG_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !pd); // R11

    AST_FLAG_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_rst && !wd_clr) |=> !to); // R9

    AST_FLAG_PD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_rst && !wd_clr && !sleep) |=> (pd == $past(pd))); // R9

endmodule

// File: rtl/tmr_wdt_top.sv
module tmr_wdt_top #(
    parameter int TMR_W = 8,
    parameter int WD_W  = 8,
    parameter int SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wdt_tick,
    input  logic                 ctl_we,
    input  logic [2*SEL_W:0]     ctl_wdata,
    output logic [2*SEL_W+1:0]   ctl_q,
    input  logic                 tmr_we,
    input  logic [TMR_W-1:0]     tmr_wdata,
    output logic [TMR_W-1:0]     tmr_q,
    output logic                 tmr_ovf,
    input  logic                 wdt_clr,
    input  logic                 sleep_req,
    input  logic                 wdt_en,
    input  logic                 cfg_wdt_allow,
    output logic                 wdt_rst,
    output logic                 flag_to,
    output logic                 flag_pd
);
    localparam int                CTL_W   = 2 * SEL_W + 1;
    localparam logic [CTL_W-1:0] CTL_RST = {1'b0, {(2 * SEL_W){1'b1}}};

    logic [CTL_W-1:0] ctl;
    logic [SEL_W-1:0] tsel;
    logic [SEL_W-1:0] wsel;
    logic             wd_enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl <= CTL_RST;
        else if (wdt_rst) ctl <= CTL_RST;
        else if (ctl_we)  ctl <= ctl_wdata;
    end

    assign ctl_q     = {1'b0, ctl};
    assign tsel      = ctl[2*SEL_W-1:SEL_W];
    assign wsel      = ctl[SEL_W-1:0];
    assign wd_enable = wdt_en & cfg_wdt_allow;

    tw_timer #(.W(TMR_W), .SEL_W(SEL_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (wdt_rst),
        .wr       (tmr_we),
        .wdata    (tmr_wdata),
        .sel      (tsel),
        .q        (tmr_q),
        .ovf      (tmr_ovf)
    );

    tw_watchdog #(.W(WD_W), .SEL_W(SEL_W)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (wd_enable),
        .clr     (wdt_clr),
        .tick_in (wdt_tick),
        .sel     (wsel),
        .fire    (wdt_rst)
    );

    tw_status_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wd_clr (wdt_clr),
        .sleep  (sleep_req),
        .wd_rst (wdt_rst),
        .to     (flag_to),
        .pd     (flag_pd)
    );

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !wdt_rst) |=> (ctl_q == {1'b0, $past(ctl_wdata)})); // R2

    AST_CTL_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> (ctl_q == {1'b0, CTL_RST})); // R9

endmodule

// File: tb/tmr_wdt_top_tb.sv
`timescale 1ns/1ps
module tmr_wdt_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       ctl_we = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic [7:0] ctl_q;
    logic       tmr_we = 1'b0;
    logic [7:0] tmr_wdata = '0;
    logic [7:0] tmr_q;
    logic       tmr_ovf;
    logic       wdt_clr = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wdt_en = 1'b0;
    logic       cfg_wdt_allow = 1'b1;
    logic       wdt_rst;
    logic       flag_to;
    logic       flag_pd;

    always #10 clk = ~clk;

    tmr_wdt_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wdt_tick      (wdt_tick),
        .ctl_we        (ctl_we),
        .ctl_wdata     (ctl_wdata),
        .ctl_q         (ctl_q),
        .tmr_we        (tmr_we),
        .tmr_wdata     (tmr_wdata),
        .tmr_q         (tmr_q),
        .tmr_ovf       (tmr_ovf),
        .wdt_clr       (wdt_clr),
        .sleep_req     (sleep_req),
        .wdt_en        (wdt_en),
        .cfg_wdt_allow (cfg_wdt_allow),
        .wdt_rst       (wdt_rst),
        .flag_to       (flag_to),
        .flag_pd       (flag_pd)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int m_t, m_tp, m_ovf, m_ctl, m_st, m_wc, m_wp, m_to, m_pd;

    always @(posedge clk) begin : ref_model
        int fire, en, tsel, wsel;
        if (!rst_n) begin
            m_t = 0; m_tp = 0; m_ovf = 0; m_ctl = 'h3F;
            m_st = 0; m_wc = 0; m_wp = 0; m_to = 1; m_pd = 1;
        end else begin
            fire = (m_st == 2) ? 1 : 0;
            en   = (wdt_en && cfg_wdt_allow) ? 1 : 0;
            tsel = (m_ctl >> 3) & 7;
            wsel = m_ctl & 7;
            case (m_st)
                1: begin
                    if (en == 0) begin
                        m_wc = 0; m_wp = 0; m_st = 0;
                    end else if (wdt_clr) begin
                        m_wc = 0; m_wp = 0;
                    end else if (wdt_tick) begin
                        if (m_wp >= (1 << wsel) - 1) begin
                            m_wp = 0;
                            if (m_wc == 255) begin
                                m_wc = 0; m_st = 2;
                            end else begin
                                m_wc++;
                            end
                        end else begin
                            m_wp++;
                        end
                    end
                end
                default: begin
                    m_wc = 0; m_wp = 0; m_st = en;
                end
            endcase
            if (fire != 0) begin
                m_t = 0; m_tp = 0; m_ovf = 0; m_ctl = 'h3F;
            end else begin
                if (tmr_we) begin
                    m_t = tmr_wdata; m_tp = 0; m_ovf = 0;
                end else if (m_tp >= (1 << (tsel + 1)) - 1) begin
                    m_tp = 0;
                    m_ovf = (m_t == 255) ? 1 : 0;
                    m_t = (m_t + 1) % 256;
                end else begin
                    m_tp++; m_ovf = 0;
                end
                if (ctl_we) m_ctl = ctl_wdata;
            end
            if (wdt_clr)         m_to = 1;
            else if (fire != 0)  m_to = 0;
            if (sleep_req)       m_pd = 0;
            else if (wdt_clr)    m_pd = 1;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 timer value", tmr_q, m_t);
            chk("R2 control readback", ctl_q, m_ctl);
            chk("R5 overflow pulse", tmr_ovf, m_ovf);
            chk("R8 watchdog reset", wdt_rst, (m_st == 2) ? 1 : 0);
            chk("R10 time-out flag", flag_to, m_to);
            chk("R11 power-down flag", flag_pd, m_pd);
        end
    end

    initial begin
        #(20 * 190000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic logic [31:0] rnd(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic write_ctl(input logic [6:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    initial begin
        logic [31:0] s;
        logic [31:0] r;
        int fires;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ctl reset", ctl_q, 'h3F);
        chk("R1 timer reset", tmr_q, 0);
        chk("R1 to reset", flag_to, 1);
        chk("R1 pd reset", flag_pd, 1);
        chk("R1 ovf reset", tmr_ovf, 0);
        chk("R1 wdt_rst reset", wdt_rst, 0);

        // R2 control register
        write_ctl(7'h7F);
        chk("R2 write all ones", ctl_q, 'h7F);
        write_ctl(7'h00);
        chk("R2 write zero", ctl_q, 'h00);

        @(negedge clk); wdt_en = 1'b1;
        repeat (2) @(negedge clk);

        // R4 / R5: load 0xFF at ratio 1:2
        tmr_we = 1'b1; tmr_wdata = 8'hFF;
        @(negedge clk); tmr_we = 1'b0;
        chk("R4 load value", tmr_q, 'hFF);
        @(negedge clk);
        @(negedge clk);
        chk("R5 overflow high", tmr_ovf, 1);
        chk("R5 wrapped value", tmr_q, 0);
        @(negedge clk);
        chk("R5 overflow one cycle", tmr_ovf, 0);

        // R3: ratio 1:16, load clears prescaler
        write_ctl(7'h18);
        tmr_we = 1'b1; tmr_wdata = 8'h00;
        @(negedge clk); tmr_we = 1'b0;
        repeat (14) @(negedge clk);
        @(negedge clk);
        chk("R3 before 16 clocks", tmr_q, 0);
        @(negedge clk);
        chk("R3 after 16 clocks", tmr_q, 1);

        // R8 / R9: watchdog expiry at 1:1
        write_ctl(7'h00);
        wdt_clr = 1'b1;
        repeat (256) begin
            @(negedge clk);
            wdt_clr = 1'b0;
            wdt_tick = 1'b1;
        end
        @(negedge clk); wdt_tick = 1'b0;
        chk("R8 pulse asserted", wdt_rst, 1);
        @(negedge clk);
        chk("R8 pulse one cycle", wdt_rst, 0);
        chk("R9 timer cleared", tmr_q, 0);
        chk("R9 control restored", ctl_q, 'h3F);
        chk("R9 time-out low", flag_to, 0);
        chk("R9 power-down kept", flag_pd, 1);

        // R10: clear coinciding with the 256th advance
        write_ctl(7'h00);
        wdt_clr = 1'b1;
        repeat (255) begin
            @(negedge clk);
            wdt_clr = 1'b0;
            wdt_tick = 1'b1;
        end
        @(negedge clk); wdt_tick = 1'b1; wdt_clr = 1'b1;
        @(negedge clk); wdt_tick = 1'b0; wdt_clr = 1'b0;
        chk("R10 clear suppresses pulse", wdt_rst, 0);
        chk("R10 time-out set", flag_to, 1);
        @(negedge clk);
        chk("R10 still no pulse", wdt_rst, 0);

        // R6: ratio 1:2 needs 512 strobes
        write_ctl(7'h01);
        wdt_clr = 1'b1;
        repeat (511) begin
            @(negedge clk);
            wdt_clr = 1'b0;
            wdt_tick = 1'b1;
        end
        @(negedge clk);
        chk("R6 no pulse at 511", wdt_rst, 0);
        @(negedge clk); wdt_tick = 1'b0;
        chk("R6 pulse at 512", wdt_rst, 1);

        // R11: sleep against clear
        @(negedge clk); sleep_req = 1'b1; wdt_clr = 1'b1;
        @(negedge clk); sleep_req = 1'b0; wdt_clr = 1'b0;
        chk("R11 sleep wins", flag_pd, 0);
        chk("R11 to from clear", flag_to, 1);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        chk("R11 to unchanged", flag_to, 1);
        @(negedge clk); wdt_clr = 1'b1;
        @(negedge clk); wdt_clr = 1'b0;
        chk("R11 clear restores pd", flag_pd, 1);

        // R7: override and enable each block the watchdog
        write_ctl(7'h00);
        cfg_wdt_allow = 1'b0;
        fires = 0;
        repeat (600) begin
            @(negedge clk);
            wdt_tick = 1'b1;
            if (wdt_rst) fires++;
        end
        chk("R7 override blocks", fires, 0);
        cfg_wdt_allow = 1'b1; wdt_en = 1'b0;
        fires = 0;
        repeat (600) begin
            @(negedge clk);
            if (wdt_rst) fires++;
        end
        chk("R7 enable blocks", fires, 0);
        wdt_en = 1'b1;

        // Free-running mix
        s = 32'h1BAD_C0DE;
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            s = rnd(s); r = s;
            wdt_tick  = r[0] | r[1];
            wdt_clr   = (r[15:6] == 10'd0);
            sleep_req = (r[24:17] == 8'd0);
            tmr_we    = (r[31:26] == 6'd0);
            s = rnd(s);
            tmr_wdata = s[7:0];
            ctl_we    = (s[14:8] == 7'd0);
            ctl_wdata = {s[21:18], 1'b0, s[17:16]};
            if (s[31:20] == 12'd0) wdt_en = ~wdt_en;
            if (s[31:19] == 13'd1) cfg_wdt_allow = ~cfg_wdt_allow;
        end
        @(negedge clk);
        wdt_tick = 1'b0; wdt_clr = 1'b0; sleep_req = 1'b0;
        tmr_we = 1'b0; ctl_we = 1'b0;
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule